// File: doc/BRIEF.md
# Single-Step Debug State Controller

This block follows a processor core through software single-stepping, one instruction at a time. The register file and the pipeline sit outside it, and so does the policy that decides where debug is enabled. They hand in a few decoded facts: whether stepping is enabled, the current debug mask, the details of each exception return, each instruction fetch, and each exclusive load or clear. From these the block works out whether the next fetch must be replaced by a step exception.

An exception return can arm stepping. The saved step bit then picks one of two active states. In the armed state (active, not pending) the next fetch lets exactly one instruction run and sets a stepped flag. In the pending state (active, pending) the next fetch raises a step request and turns off the breakpoint check for that fetch. The block also supplies what the exception entry logic needs. That is the exception class, which depends on the target level, and the syndrome word, which carries the stepped flag and the previous exclusive-load flag. It also supplies the hypervisor routing decision and the step bit to be saved when any exception is taken.

The states are idle (inactive), pend (active, pending) and armed (active, not pending), encoded 0, 1 and 2 on `step_state`. The transitions are named below. Reset goes to idle. Arm-pend goes from any state to pend, on an arming exception return whose saved bit is 0. Arm-run goes from any state to armed, on an arming exception return whose saved bit is 1. Run-step goes from armed to pend, on a fetch with stepping allowed. Run-drop goes from armed to idle, on a fetch with the mask set or stepping disabled. Fire goes from pend to idle on any fetch. Idle-hold keeps idle on a fetch.

Top module: `sstep_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `step_state` is 0 (idle), `step_req` is 0 and both syndrome flag bits are 0.
- R2: An exception return arms stepping only if all three hold: `step_en` is 1, `eret_src_dbg_en` is 0 and `eret_dst_dbg_en` is 1, and `eret_tgt_a64` is 1. `eret_ss` equals `eret_saved_ss` when the return arms and is 0 otherwise. A return that does not arm leaves `step_state` unchanged.
- R3: An arming return moves the state to pend (1) if `eret_saved_ss` is 0, and to armed (2) if it is 1. The new state is visible in the next cycle.
- R4: A fetch in armed moves the state to idle if `dbg_mask` is 1 or `step_en` is 0. Otherwise it sets the stepped flag and moves the state to pend.
- R5: A fetch in pend drives `step_req` high in that same cycle when `dbg_mask` is 0 and `step_en` is 1. The state always moves to idle, and the exclusive-load flag is cleared.
- R6: `bkpt_chk_en` is 1 on an accepted fetch, except when `step_req` is 1 in that cycle.
- R7: The exclusive-load tracker holds a current and a previous value. `excl_set` copies current into previous and then sets current. A clear copies current into previous and then clears current. A clear comes from `excl_clr` or from a fetch in pend. If a set and a clear arrive in the same cycle, the set wins.
- R8: `step_ec` is 0x33 when the effective target level equals `src_el`, and 0x32 otherwise. The effective target level is 2 when `route_hyp` is 1, and `dflt_tgt_el` otherwise.
- R9: `step_syndrome` is 0x22. Bit 24 is set from the stepped flag and bit 6 from the previous exclusive-load value.
- R10: `route_hyp` is 1 only when all of these hold: `el2_present` is 1, `nonsecure` is 1, `src_el` is 1 or lower, and `trap_general` or `trap_debug` is 1.
- R11: During `exc_entry`, `exc_saved_ss` is 0 when `exc_ss_clears` is 1 (step, supervisor, hypervisor and monitor calls), and `cur_ss` otherwise. It is 0 when `exc_entry` is low.
- R12: `exc_entry` clears the stepped flag. It wins over a set in the same cycle.
- R13: A fetch in idle never raises `step_req`, and a fetch with `step_en` at 0 never leaves idle. When `eret_valid` and `fetch_valid` are both high, the fetch is ignored: no `step_req`, no `bkpt_chk_en`, and no fetch transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Software step enable |
| dbg_mask | input | 1 | Debug exception mask |
| eret_valid | input | 1 | Exception return this cycle |
| eret_saved_ss | input | 1 | Step bit from the saved status |
| eret_src_dbg_en | input | 1 | Debug enabled at the return's source level |
| eret_dst_dbg_en | input | 1 | Debug enabled at the return's destination level |
| eret_tgt_a64 | input | 1 | Debug target level runs the 64-bit state |
| eret_ss | output | 1 | Step bit to load into the live status |
| fetch_valid | input | 1 | Instruction fetch this cycle |
| step_req | output | 1 | Take a step exception for this fetch |
| bkpt_chk_en | output | 1 | Breakpoint check allowed for this fetch |
| step_state | output | 2 | 0 idle, 1 pend, 2 armed |
| excl_set | input | 1 | Exclusive load executed |
| excl_clr | input | 1 | Clear the exclusive-load flag |
| exc_entry | input | 1 | An exception is being taken |
| exc_ss_clears | input | 1 | The exception is a step or call type |
| cur_ss | input | 1 | Current live step bit |
| exc_saved_ss | output | 1 | Step bit to save on exception entry |
| el2_present | input | 1 | Hypervisor level implemented |
| nonsecure | input | 1 | Non-secure state |
| src_el | input | 2 | Level the exception comes from |
| dflt_tgt_el | input | 2 | Target level when not routed up |
| trap_general | input | 1 | General trap-to-hypervisor control |
| trap_debug | input | 1 | Debug trap-to-hypervisor control |
| route_hyp | output | 1 | Step exception goes to the hypervisor level |
| step_ec | output | 6 | Exception class for a step exception |
| step_syndrome | output | 25 | Syndrome for a step exception |

## Verification
An exception return and a fetch can fall in the same cycle. The return must win: it arms or leaves the state as it is, and the fetch raises no request and no breakpoint check. The stimulus drives both strobes together, in both directed and random cycles, while the machine sits in every state. A reference model that knows nothing of the design's structure judges each such cycle by its outputs and by `step_state` one cycle later. A second collision is an `excl_set` in the same cycle as the clear caused by a pend fetch. The syndrome's bit 6 after the next clear shows whether the set won.

// File: rtl/sstep_pkg.sv
package sstep_pkg;

    typedef enum logic [1:0] {
        SS_IDLE  = 2'd0,
        SS_PEND  = 2'd1,
        SS_ARMED = 2'd2
    } ss_state_e;

    localparam int SS_EC_SAME     = 'h33;
    localparam int SS_EC_LOWER    = 'h32;
    localparam int SS_SYND_BASE   = 'h22;
    localparam int SS_STEPPED_BIT = 24;
    localparam int SS_EXCL_BIT    = 6;
    localparam int SS_HYP_EL      = 2;

endpackage

// File: rtl/sstep_fsm.sv
module sstep_fsm
    import sstep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step_en,
    input  logic      dbg_mask,
    input  logic      eret_valid,
    input  logic      eret_saved_ss,
    input  logic      eret_src_dbg_en,
    input  logic      eret_dst_dbg_en,
    input  logic      eret_tgt_a64,
    input  logic      fetch_valid,
    output logic      eret_ss,
    output logic      fetch_eff,
    output logic      step_req,
    output logic      set_stepped,
    output logic      fetch_excl_clr,
    output ss_state_e state
);

    ss_state_e state_nxt;
    logic      arm;

    assign arm       = eret_valid & step_en & ~eret_src_dbg_en
                     & eret_dst_dbg_en & eret_tgt_a64;
    assign fetch_eff = fetch_valid & ~eret_valid;

    // next state
    always_comb begin
        state_nxt = state;
        if (arm) begin
            state_nxt = eret_saved_ss ? SS_ARMED : SS_PEND;
        end else if (fetch_eff) begin
            unique case (state)
                SS_IDLE:  state_nxt = SS_IDLE;
                SS_ARMED: state_nxt = (dbg_mask || !step_en) ? SS_IDLE : SS_PEND;
                SS_PEND:  state_nxt = SS_IDLE;
                default:  state_nxt = SS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SS_IDLE;
        else        state <= state_nxt;
    end

    // outputs
    always_comb begin
        eret_ss        = arm & eret_saved_ss;
        step_req       = 1'b0;
        set_stepped    = 1'b0;
        fetch_excl_clr = 1'b0;
        if (fetch_eff) begin
            unique case (state)
                SS_IDLE:  ;
                SS_ARMED: set_stepped = ~dbg_mask & step_en;
                SS_PEND: begin
                    step_req       = ~dbg_mask & step_en;
                    fetch_excl_clr = 1'b1;
                end
                default:  ;
            endcase
        end
    end

    // R3
    arm_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !eret_saved_ss) |=> state == SS_PEND);

    // R5
    fire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |=> state == SS_IDLE);

    // R4
    run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_eff && state == SS_ARMED && (dbg_mask || !step_en)) |=> state == SS_IDLE);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_IDLE || eret_valid) |-> !step_req);

endmodule

// File: rtl/sstep_excl.sv
module sstep_excl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic cur_o,
    output logic prev_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_o  <= 1'b0;
            prev_o <= 1'b0;
        end else if (set_i || clr_i) begin
            prev_o <= cur_o;
            cur_o  <= set_i;
        end
    end

    // R7
    excl_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i || clr_i) |=> (prev_o == $past(cur_o)) && (cur_o == $past(set_i)));

endmodule

// File: rtl/sstep_synd.sv
module sstep_synd
    import sstep_pkg::*;
#(
    parameter int EL_W   = 2,
    parameter int EC_W   = 6,
    parameter int SYND_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stepped,
    input  logic              excl_prev,
    input  logic              exc_entry,
    input  logic              exc_ss_clears,
    input  logic              cur_ss,
    input  logic              el2_present,
    input  logic              nonsecure,
    input  logic [EL_W-1:0]   src_el,
    input  logic [EL_W-1:0]   dflt_tgt_el,
    input  logic              trap_general,
    input  logic              trap_debug,
    output logic              route_hyp,
    output logic [EC_W-1:0]   step_ec,
    output logic [SYND_W-1:0] step_syndrome,
    output logic              exc_saved_ss
);

    localparam logic [EL_W-1:0] HYP_EL = EL_W'(SS_HYP_EL);
    localparam logic [EL_W-1:0] EL_ONE = EL_W'(1);

    logic [EL_W-1:0] eff_tgt;

    always_comb begin
        route_hyp = el2_present & nonsecure & (src_el <= EL_ONE)
                  & (trap_general | trap_debug);
        eff_tgt   = route_hyp ? HYP_EL : dflt_tgt_el;
        step_ec   = (eff_tgt == src_el) ? EC_W'(SS_EC_SAME) : EC_W'(SS_EC_LOWER);
        step_syndrome = SYND_W'(SS_SYND_BASE);
        step_syndrome[SS_STEPPED_BIT] = stepped;
        step_syndrome[SS_EXCL_BIT]    = excl_prev;
        exc_saved_ss  = exc_entry & ~exc_ss_clears & cur_ss;
    end

    // R8
    ec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ec == EC_W'(SS_EC_SAME)) || (step_ec == EC_W'(SS_EC_LOWER)));

    // R10
    route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_hyp |-> (el2_present && nonsecure && src_el <= EL_ONE));

endmodule

// File: rtl/sstep_ctrl.sv
module sstep_ctrl
    import sstep_pkg::*;
#(
    parameter int EL_W   = 2,
    parameter int EC_W   = 6,
    parameter int SYND_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              dbg_mask,
    input  logic              eret_valid,
    input  logic              eret_saved_ss,
    input  logic              eret_src_dbg_en,
    input  logic              eret_dst_dbg_en,
    input  logic              eret_tgt_a64,
    output logic              eret_ss,
    input  logic              fetch_valid,
    output logic              step_req,
    output logic              bkpt_chk_en,
    output logic [1:0]        step_state,
    input  logic              excl_set,
    input  logic              excl_clr,
    input  logic              exc_entry,
    input  logic              exc_ss_clears,
    input  logic              cur_ss,
    output logic              exc_saved_ss,
    input  logic              el2_present,
    input  logic              nonsecure,
    input  logic [EL_W-1:0]   src_el,
    input  logic [EL_W-1:0]   dflt_tgt_el,
    input  logic              trap_general,
    input  logic              trap_debug,
    output logic              route_hyp,
    output logic [EC_W-1:0]   step_ec,
    output logic [SYND_W-1:0] step_syndrome
);

    ss_state_e state;
    logic      fetch_eff;
    logic      set_stepped;
    logic      fetch_excl_clr;
    logic      stepped;
    logic      excl_cur;
    logic      excl_prev;

    sstep_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .step_en         (step_en),
        .dbg_mask        (dbg_mask),
        .eret_valid      (eret_valid),
        .eret_saved_ss   (eret_saved_ss),
        .eret_src_dbg_en (eret_src_dbg_en),
        .eret_dst_dbg_en (eret_dst_dbg_en),
        .eret_tgt_a64    (eret_tgt_a64),
        .fetch_valid     (fetch_valid),
        .eret_ss         (eret_ss),
        .fetch_eff       (fetch_eff),
        .step_req        (step_req),
        .set_stepped     (set_stepped),
        .fetch_excl_clr  (fetch_excl_clr),
        .state           (state)
    );

    sstep_excl u_excl (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (excl_set),
        .clr_i  (excl_clr | fetch_excl_clr),
        .cur_o  (excl_cur),
        .prev_o (excl_prev)
    );

    sstep_synd #(
        .EL_W   (EL_W),
        .EC_W   (EC_W),
        .SYND_W (SYND_W)
    ) u_synd (
        .clk           (clk),
        .rst_n         (rst_n),
        .stepped       (stepped),
        .excl_prev     (excl_prev),
        .exc_entry     (exc_entry),
        .exc_ss_clears (exc_ss_clears),
        .cur_ss        (cur_ss),
        .el2_present   (el2_present),
        .nonsecure     (nonsecure),
        .src_el        (src_el),
        .dflt_tgt_el   (dflt_tgt_el),
        .trap_general  (trap_general),
        .trap_debug    (trap_debug),
        .route_hyp     (route_hyp),
        .step_ec       (step_ec),
        .step_syndrome (step_syndrome),
        .exc_saved_ss  (exc_saved_ss)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           stepped <= 1'b0;
        else if (exc_entry)   stepped <= 1'b0;
        else if (set_stepped) stepped <= 1'b1;
    end

    assign bkpt_chk_en = fetch_eff & ~step_req;
    assign step_state  = state;

    // R6
    bkpt_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> !bkpt_chk_en);

    // R12
    stepped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> !stepped);

    // R7
    excl_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_excl_clr && !excl_set) |=> !excl_cur);

endmodule

// File: tb/tb_sstep_ctrl.sv
module tb_sstep_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_en = 0, dbg_mask = 0;
    logic eret_valid = 0, eret_saved_ss = 0, eret_src_dbg_en = 0;
    logic eret_dst_dbg_en = 0, eret_tgt_a64 = 0;
    logic fetch_valid = 0, excl_set = 0, excl_clr = 0;
    logic exc_entry = 0, exc_ss_clears = 0, cur_ss = 0;
    logic el2_present = 0, nonsecure = 0, trap_general = 0, trap_debug = 0;
    logic [1:0] src_el = 0, dflt_tgt_el = 0;
    logic eret_ss, step_req, bkpt_chk_en, exc_saved_ss, route_hyp;
    logic [1:0] step_state;
    logic [5:0] step_ec;
    logic [24:0] step_syndrome;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int m_st = 0;
    bit m_stepped = 0, m_xcur = 0, m_xprev = 0;

    always #2 clk = ~clk;

    sstep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .dbg_mask(dbg_mask),
        .eret_valid(eret_valid), .eret_saved_ss(eret_saved_ss),
        .eret_src_dbg_en(eret_src_dbg_en), .eret_dst_dbg_en(eret_dst_dbg_en),
        .eret_tgt_a64(eret_tgt_a64), .eret_ss(eret_ss),
        .fetch_valid(fetch_valid), .step_req(step_req),
        .bkpt_chk_en(bkpt_chk_en), .step_state(step_state),
        .excl_set(excl_set), .excl_clr(excl_clr), .exc_entry(exc_entry),
        .exc_ss_clears(exc_ss_clears), .cur_ss(cur_ss),
        .exc_saved_ss(exc_saved_ss), .el2_present(el2_present),
        .nonsecure(nonsecure), .src_el(src_el), .dflt_tgt_el(dflt_tgt_el),
        .trap_general(trap_general), .trap_debug(trap_debug),
        .route_hyp(route_hyp), .step_ec(step_ec), .step_syndrome(step_syndrome)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit arms();
        return eret_valid && step_en && !eret_src_dbg_en && eret_dst_dbg_en && eret_tgt_a64;
    endfunction

    function automatic bit fetch_ok();
        return fetch_valid && !eret_valid;
    endfunction

    // compare every cycle, away from the clock edge
    always @(negedge clk) begin
        bit req, route;
        int tgt;
        req   = fetch_ok() && m_st == 1 && !dbg_mask && step_en;
        route = el2_present && nonsecure && src_el <= 1 && (trap_general || trap_debug);
        tgt   = route ? 2 : int'(dflt_tgt_el);
        chk("R1/R3/R4 step_state", step_state, m_st);
        chk("R2 eret_ss", eret_ss, arms() ? eret_saved_ss : 0);
        chk("R5/R13 step_req", step_req, req);
        chk("R6 bkpt_chk_en", bkpt_chk_en, fetch_ok() && !req);
        chk("R10 route_hyp", route_hyp, route);
        chk("R8 step_ec", step_ec, (tgt == int'(src_el)) ? 'h33 : 'h32);
        chk("R9/R7/R12 step_syndrome", step_syndrome,
            'h22 | (m_stepped ? (1 << 24) : 0) | (m_xprev ? (1 << 6) : 0));
        chk("R11 exc_saved_ss", exc_saved_ss, exc_entry && !exc_ss_clears && cur_ss);
    end

    // model update
    always @(posedge clk) begin
        bit setstep, fclr;
        setstep = 0;
        fclr = 0;
        if (!rst_n) begin
            m_st = 0; m_stepped = 0; m_xcur = 0; m_xprev = 0;
        end else begin
            if (arms()) m_st = eret_saved_ss ? 2 : 1;
            else if (fetch_ok()) begin
                if (m_st == 2) begin
                    if (dbg_mask || !step_en) m_st = 0;
                    else begin m_st = 1; setstep = 1; end
                end else if (m_st == 1) begin
                    m_st = 0; fclr = 1;
                end
            end
            if (exc_entry) m_stepped = 0;
            else if (setstep) m_stepped = 1;
            if (excl_set) begin m_xprev = m_xcur; m_xcur = 1; end
            else if (excl_clr || fclr) begin m_xprev = m_xcur; m_xcur = 0; end
        end
    end

    task automatic idle_inputs();
        eret_valid = 0; fetch_valid = 0; excl_set = 0; excl_clr = 0; exc_entry = 0;
    endtask

    task automatic do_eret(input bit ss);
        @(posedge clk); #1;
        idle_inputs();
        eret_valid = 1; eret_saved_ss = ss; eret_src_dbg_en = 0;
        eret_dst_dbg_en = 1; eret_tgt_a64 = 1;
    endtask

    task automatic do_fetch(input bit xs);
        @(posedge clk); #1;
        idle_inputs();
        fetch_valid = 1; excl_set = xs;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset held, then released
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step_en = 1;
        // R3/R5: arm with saved bit 0, next fetch fires
        do_eret(0);
        do_fetch(0);
        // R4/R9/R7: arm with 1, run one exclusive load, then fire
        do_eret(1);
        do_fetch(0);
        @(posedge clk); #1; idle_inputs(); excl_set = 1;
        do_fetch(0);
        @(posedge clk); #1; idle_inputs();
        // R12/R11: exception entry clears stepped
        exc_entry = 1; exc_ss_clears = 1; cur_ss = 1;
        @(posedge clk); #1; exc_ss_clears = 0;
        // R13: eret and fetch together while pending
        do_eret(0);
        @(posedge clk); #1; idle_inputs();
        eret_valid = 1; fetch_valid = 1; eret_saved_ss = 1;
        // R4: mask drops the armed state
        do_fetch(0);
        dbg_mask = 1;
        do_eret(1);
        do_fetch(0);
        dbg_mask = 0;
        // R2: non-arming return leaves state
        @(posedge clk); #1; idle_inputs();
        eret_valid = 1; eret_src_dbg_en = 1;
        // R10/R8: routing cases
        @(posedge clk); #1; idle_inputs();
        el2_present = 1; nonsecure = 1; src_el = 1; trap_debug = 1; dflt_tgt_el = 1;
        @(posedge clk); #1; src_el = 2;
        @(posedge clk); #1; trap_debug = 0; dflt_tgt_el = 2;
        // random mix
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            step_en         = ($urandom_range(0, 9) < 8);
            dbg_mask        = ($urandom_range(0, 9) < 2);
            eret_valid      = ($urandom_range(0, 9) < 2);
            eret_saved_ss   = $urandom_range(0, 1);
            eret_src_dbg_en = ($urandom_range(0, 3) == 0);
            eret_dst_dbg_en = ($urandom_range(0, 3) != 0);
            eret_tgt_a64    = ($urandom_range(0, 3) != 0);
            fetch_valid     = ($urandom_range(0, 9) < 6);
            excl_set        = ($urandom_range(0, 9) < 2);
            excl_clr        = ($urandom_range(0, 9) < 1);
            exc_entry       = ($urandom_range(0, 9) < 1);
            exc_ss_clears   = $urandom_range(0, 1);
            cur_ss          = $urandom_range(0, 1);
            el2_present     = $urandom_range(0, 1);
            nonsecure       = $urandom_range(0, 1);
            trap_general    = $urandom_range(0, 1);
            trap_debug      = $urandom_range(0, 1);
            src_el          = 2'($urandom_range(0, 3));
            dflt_tgt_el     = 2'($urandom_range(0, 3));
        end
        @(posedge clk); #1; idle_inputs();
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule